// File: doc/BRIEF.md
# I2C Master Bus Control Sequencer

This block holds the control and clock-divider settings for an I2C controller and turns software edits of those settings into commands for a separate bit-level bus engine. Software sets or clears a single master-select bit, and the block turns that edit into a one-cycle START or STOP request. The engine can report a lost arbitration, and the block then drops back to slave mode on its own without asking for a STOP.

A disable bit keeps the engine in reset while both registers stay readable and writable. While the block is disabled, every mode and enable output is held low. After the block is enabled, the slave side stays idle until it sees a fresh START on the bus, so a transfer already under way is ignored. The block also decodes an 8-bit divider code into an SCL period and three hold counts. It gates the engine's interrupt flag with an enable bit.

Top module: `i2c_bus_ctrl_seq`

## Requirements
- R1: After reset, the control register (address 0) reads 0x80 and the divider register (address 1) reads 0x00. engine_rst_o is 1. All mode, enable, request and interrupt outputs are 0.
- R2: A write with reg_addr_i=0 stores control bits [7:1] and bit 0 always reads 0. A write with reg_addr_i=1 stores the divider code. reg_rdata_o shows the register selected by reg_addr_i, and a write becomes visible in the cycle after the clock edge that takes it. Control layout: bit7 disable, bit6 interrupt enable, bit5 master select, bit4 transmit, bit3 no-acknowledge, bit2 repeated start, bit1 DMA enable.
- R3: While the stored disable bit is 1, engine_rst_o is 1 and master_o, tx_o, noack_o, rep_start_o, dma_en_o, irq_o and slave_active_o are all 0. A write changes the master bit only when both the stored and the written disable bits are 0. Any other write raises no START or STOP request.
- R4: When the block is enabled, a write that changes the master bit from 0 to 1 drives start_req_o high for exactly one cycle, the cycle after the write edge. master_o becomes 1 at the same time.
- R5: When the block is enabled, a write that changes the master bit from 1 to 0 drives stop_req_o high for exactly one cycle, the cycle after the write edge. master_o becomes 0 at the same time. start_req_o and stop_req_o are never high together.
- R6: If arb_lost_i is 1 while the block is enabled and in master mode, the hardware clears the master bit at that edge and raises no STOP. This also holds when a write clearing the master bit arrives in the same cycle.
- R7: irq_o = interrupt enable AND irq_flag_i AND NOT disable. Clearing interrupt enable masks irq_o, and irq_o comes back once the enable is set again while the flag is still high.
- R8: slave_active_o is 1 only after a bus_start_i pulse has been seen while the block was enabled and in slave mode. It clears on disable or on entry to master mode, and stays 0 until the next bus_start_i pulse.
- R9: With M=2^code[7:6], P=code[5:3], T=code[2:0], base=B(P)+(S(T)-1)*2^P, the block outputs scl_div_o=2*M*(base+2), start_hold_o=M*base, stop_hold_o=M*(base+3) and sda_hold_o=M*(B(P)+(D(T)-1)*2^P+3). Here B={4,4,6,6,14,30,62,126}, S={5,6,7,8,9,10,12,15} and D={1,1,2,2,3,3,4,4}. Code 0xBB gives 8192/1028/4088/4100 and code 0xBF gives 15360/2052/7672/7684.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control, 1 = divider |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| arb_lost_i | input | 1 | Engine reports lost arbitration |
| irq_flag_i | input | 1 | Pending interrupt flag from status |
| bus_start_i | input | 1 | START condition detected on bus |
| engine_rst_o | output | 1 | Hold bus engine in reset |
| master_o | output | 1 | Master mode level |
| tx_o | output | 1 | Transmit direction level |
| noack_o | output | 1 | Suppress acknowledge level |
| rep_start_o | output | 1 | Repeated-start level |
| dma_en_o | output | 1 | DMA enable level |
| irq_o | output | 1 | Gated interrupt |
| slave_active_o | output | 1 | Slave side armed |
| start_req_o | output | 1 | One-cycle START request |
| stop_req_o | output | 1 | One-cycle STOP request |
| scl_div_o | output | 16 | SCL period in clocks |
| sda_hold_o | output | 16 | SDA hold in clocks |
| start_hold_o | output | 16 | START hold in clocks |
| stop_hold_o | output | 16 | STOP hold in clocks |

## Verification
The hardest situation to reach is an arbitration loss that arrives in the same cycle as a software write clearing the master bit, because only this case separates "loss wins" from "write wins". The bench reaches it by first entering master mode with a normal write. It then drives the clearing write and arb_lost_i in the same cycle and checks that stop_req_o stays low. A second hard case is enabling mid-transfer: the bench enables the block with no START present and checks that slave_active_o stays low. Only a later bus_start_i pulse may arm the slave side.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;
  localparam int unsigned REG_W = 8;
  // Control bit positions; software and engine both depend on this order
  localparam int unsigned B_DIS  = 7;
  localparam int unsigned B_IE   = 6;
  localparam int unsigned B_MS   = 5;
  localparam int unsigned B_TX   = 4;
  localparam int unsigned B_NAK  = 3;
  localparam int unsigned B_RSTA = 2;
  localparam int unsigned B_DMA  = 1;
  localparam logic [REG_W-1:0] CTRL_RST = 8'h80;
  localparam logic [REG_W-1:0] CTRL_MASK = 8'hFE;

  typedef enum logic {ADDR_CTRL = 1'b0, ADDR_DIV = 1'b1} reg_addr_e;

  function automatic logic [7:0] base_taps(input logic [2:0] p);
    case (p)
      3'd0, 3'd1: base_taps = 8'd4;
      3'd2, 3'd3: base_taps = 8'd6;
      3'd4:       base_taps = 8'd14;
      3'd5:       base_taps = 8'd30;
      3'd6:       base_taps = 8'd62;
      default:    base_taps = 8'd126;
    endcase
  endfunction

  function automatic logic [3:0] scl_taps(input logic [2:0] t);
    case (t)
      3'd0: scl_taps = 4'd5;
      3'd1: scl_taps = 4'd6;
      3'd2: scl_taps = 4'd7;
      3'd3: scl_taps = 4'd8;
      3'd4: scl_taps = 4'd9;
      3'd5: scl_taps = 4'd10;
      3'd6: scl_taps = 4'd12;
      default: scl_taps = 4'd15;
    endcase
  endfunction

  function automatic logic [2:0] sda_taps(input logic [2:0] t);
    sda_taps = 3'd1 + {1'b0, t[2:1]};
  endfunction
endpackage

// File: rtl/i2cc_ctrl_reg.sv
module i2cc_ctrl_reg
  import i2cc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             arb_lost_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic             start_o,
  output logic             stop_o
);
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic start_q, stop_q, start_d, stop_d;
  logic dis_q, ms_q, arb_clear, en_wr;

  assign dis_q     = ctrl_q[B_DIS];
  assign ms_q      = ctrl_q[B_MS];
  assign arb_clear = arb_lost_i && ms_q && !dis_q;
  // master bit is editable only when enabled before and after the write
  assign en_wr     = wr_i && !dis_q && !wdata_i[B_DIS];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) begin
      ctrl_d = wdata_i & CTRL_MASK;
      if (!en_wr) ctrl_d[B_MS] = ms_q;
    end
    if (arb_clear) ctrl_d[B_MS] = 1'b0;
    start_d = en_wr && !arb_clear && !ms_q && wdata_i[B_MS];
    stop_d  = en_wr && !arb_clear && ms_q && !wdata_i[B_MS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign start_o = start_q;
  assign stop_o  = stop_q;

  assert_start_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  assert_stop_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |=> !stop_q);
  assert_arb_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_clear |=> (!ctrl_q[B_MS] && !stop_q));
  assert_start_master_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> ctrl_q[B_MS]);
endmodule

// File: rtl/i2cc_slave_gate.sv
module i2cc_slave_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dis_i,
  input  logic master_i,
  input  logic bus_start_i,
  output logic active_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                armed_q <= 1'b0;
    else if (dis_i || master_i) armed_q <= 1'b0;
    else if (bus_start_i)       armed_q <= 1'b1;
  end

  assign active_o = armed_q && !dis_i && !master_i;

  assert_arm_needs_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(bus_start_i));
endmodule

// File: rtl/i2cc_div_calc.sv
module i2cc_div_calc #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [7:0]       code_i,
  output logic [CNT_W-1:0] scl_div_o,
  output logic [CNT_W-1:0] sda_hold_o,
  output logic [CNT_W-1:0] start_hold_o,
  output logic [CNT_W-1:0] stop_hold_o
);
  import i2cc_pkg::*;
  localparam int unsigned SHIFT_W = 4;

  logic [1:0]       mul_sel;
  logic [2:0]       pre_sel, tap_sel;
  logic [CNT_W-1:0] b_tap, t2t, scl_base, sda_base;

  assign mul_sel = code_i[7:6];
  assign pre_sel = code_i[5:3];
  assign tap_sel = code_i[2:0];

  always_comb begin
    b_tap    = CNT_W'(base_taps(pre_sel));
    t2t      = CNT_W'(1) << pre_sel;
    scl_base = b_tap + CNT_W'(scl_taps(tap_sel) - 4'd1) * t2t;
    sda_base = b_tap + CNT_W'(sda_taps(tap_sel) - 3'd1) * t2t + CNT_W'(3);
  end

  assign start_hold_o = scl_base << SHIFT_W'(mul_sel);
  assign stop_hold_o  = (scl_base + CNT_W'(3)) << SHIFT_W'(mul_sel);
  assign sda_hold_o   = sda_base << SHIFT_W'(mul_sel);
  assign scl_div_o    = (scl_base + CNT_W'(2)) << (SHIFT_W'(mul_sel) + SHIFT_W'(1));
endmodule

// File: rtl/i2c_bus_ctrl_seq.sv
module i2c_bus_ctrl_seq
  import i2cc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             arb_lost_i,
  input  logic             irq_flag_i,
  input  logic             bus_start_i,
  output logic             engine_rst_o,
  output logic             master_o,
  output logic             tx_o,
  output logic             noack_o,
  output logic             rep_start_o,
  output logic             dma_en_o,
  output logic             irq_o,
  output logic             slave_active_o,
  output logic             start_req_o,
  output logic             stop_req_o,
  output logic [CNT_W-1:0] scl_div_o,
  output logic [CNT_W-1:0] sda_hold_o,
  output logic [CNT_W-1:0] start_hold_o,
  output logic [CNT_W-1:0] stop_hold_o
);
  logic [REG_W-1:0] ctrl, div_q;
  logic             ctrl_wr, div_wr, en;

  assign ctrl_wr = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_CTRL);
  assign div_wr  = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_DIV);

  i2cc_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctrl_wr),
    .wdata_i    (reg_wdata_i),
    .arb_lost_i (arb_lost_i),
    .ctrl_o     (ctrl),
    .start_o    (start_req_o),
    .stop_o     (stop_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (div_wr) div_q <= reg_wdata_i;
  end

  assign en           = !ctrl[B_DIS];
  assign engine_rst_o = ctrl[B_DIS];
  assign master_o     = en && ctrl[B_MS];
  assign tx_o         = en && ctrl[B_TX];
  assign noack_o      = en && ctrl[B_NAK];
  assign rep_start_o  = en && ctrl[B_RSTA];
  assign dma_en_o     = en && ctrl[B_DMA];
  assign irq_o        = en && ctrl[B_IE] && irq_flag_i;
  assign reg_rdata_o  = reg_addr_i ? div_q : ctrl;

  i2cc_slave_gate u_slave (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dis_i       (ctrl[B_DIS]),
    .master_i    (ctrl[B_MS]),
    .bus_start_i (bus_start_i),
    .active_o    (slave_active_o)
  );

  i2cc_div_calc #(.CNT_W(CNT_W)) u_div (
    .code_i       (div_q),
    .scl_div_o    (scl_div_o),
    .sda_hold_o   (sda_hold_o),
    .start_hold_o (start_hold_o),
    .stop_hold_o  (stop_hold_o)
  );

  assert_req_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_req_o && stop_req_o));
  assert_no_req_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req_o || stop_req_o) |-> !engine_rst_o);
  assert_irq_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_flag_i && !engine_rst_o));
  assert_slave_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_active_o |-> (!master_o && !engine_rst_o));
  assert_hold_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_hold_o > start_hold_o) && (scl_div_o > stop_hold_o));
endmodule

// File: tb/i2c_bus_ctrl_seq_tb_top.sv
module i2c_bus_ctrl_seq_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WD_CYCLES  = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, addr = 1'b0, arb = 1'b0, flag = 1'b0, bstart = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic eng_rst, master, tx, nak, rsta, dma, irq, sact, sreq, preq;
  logic [15:0] scl, sda, sth, sph;
  int n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_ctrl_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .arb_lost_i(arb),
    .irq_flag_i(flag), .bus_start_i(bstart), .engine_rst_o(eng_rst),
    .master_o(master), .tx_o(tx), .noack_o(nak), .rep_start_o(rsta),
    .dma_en_o(dma), .irq_o(irq), .slave_active_o(sact),
    .start_req_o(sreq), .stop_req_o(preq), .scl_div_o(scl),
    .sda_hold_o(sda), .start_hold_o(sth), .stop_hold_o(sph)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at negedge; returns at the next negedge (after the taking edge)
  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "ctrl", int'(rdata), 8'h80);
    chk("R1", "engine_rst", int'(eng_rst), 1);
    chk("R1", "levels", int'({master, tx, nak, rsta, dma, irq, sact, sreq, preq}), 0);
    addr = 1'b1; #1;
    chk("R1", "div", int'(rdata), 0);
    addr = 1'b0;
  endtask

  task automatic t_disabled;
    // all bits set while disabled: master bit must not change, no requests
    wr_reg(1'b0, 8'hFF);
    chk("R3", "start_req", int'(sreq), 0);
    chk("R3", "readback", int'(rdata), 8'hDE);
    chk("R3", "levels", int'({master, tx, nak, rsta, dma, irq, sact}), 0);
    chk("R3", "engine_rst", int'(eng_rst), 1);
    // enable alone keeps master bit 0
    wr_reg(1'b0, 8'h1E);
    chk("R2", "readback", int'(rdata), 8'h1E);
    chk("R2", "levels", int'({master, tx, nak, rsta, dma}), 5'b01111);
    chk("R3", "no start on enable", int'(sreq), 0);
  endtask

  task automatic t_slave;
    wr_reg(1'b0, 8'h00);
    repeat (3) @(negedge clk);
    chk("R8", "idle before start", int'(sact), 0);
    bstart = 1'b1; @(negedge clk); bstart = 1'b0;
    chk("R8", "armed", int'(sact), 1);
  endtask

  task automatic t_start_stop;
    wr_reg(1'b0, 8'h20);
    chk("R4", "start pulse", int'(sreq), 1);
    chk("R4", "master", int'(master), 1);
    chk("R8", "slave off in master", int'(sact), 0);
    @(negedge clk);
    chk("R4", "start one cycle", int'(sreq), 0);
    wr_reg(1'b0, 8'h30);
    chk("R4", "no repeat start", int'(sreq), 0);
    wr_reg(1'b0, 8'h10);
    chk("R5", "stop pulse", int'(preq), 1);
    chk("R5", "start low", int'(sreq), 0);
    chk("R5", "master off", int'(master), 0);
    @(negedge clk);
    chk("R5", "stop one cycle", int'(preq), 0);
    chk("R8", "slave needs new start", int'(sact), 0);
  endtask

  task automatic t_arb;
    wr_reg(1'b0, 8'h20);
    @(negedge clk);
    arb = 1'b1; @(negedge clk); arb = 1'b0;
    chk("R6", "master cleared", int'(master), 0);
    chk("R6", "readback", int'(rdata), 8'h00);
    chk("R6", "no stop", int'(preq), 0);
    @(negedge clk);
    chk("R6", "no stop later", int'(preq), 0);
    wr_reg(1'b0, 8'h20);
    @(negedge clk);
    @(negedge clk); wr = 1'b1; addr = 1'b0; wdata = 8'h00; arb = 1'b1;
    @(negedge clk); wr = 1'b0; arb = 1'b0;
    chk("R6", "same-cycle no stop", int'(preq), 0);
    chk("R6", "same-cycle master", int'(master), 0);
  endtask

  task automatic t_irq;
    flag = 1'b1;
    wr_reg(1'b0, 8'h40);
    chk("R7", "irq on", int'(irq), 1);
    wr_reg(1'b0, 8'h00);
    chk("R7", "irq masked", int'(irq), 0);
    wr_reg(1'b0, 8'h40);
    chk("R7", "flag kept", int'(irq), 1);
    flag = 1'b0; #1;
    chk("R7", "flag low", int'(irq), 0);
    flag = 1'b1;
    wr_reg(1'b0, 8'hC0);
    chk("R3", "irq when disabled", int'(irq), 0);
    flag = 1'b0;
  endtask

  function automatic int ref_b(input int p);
    case (p) 0, 1: return 4; 2, 3: return 6; 4: return 14; 5: return 30; 6: return 62; default: return 126; endcase
  endfunction
  function automatic int ref_s(input int t);
    case (t) 0: return 5; 1: return 6; 2: return 7; 3: return 8; 4: return 9; 5: return 10; 6: return 12; default: return 15; endcase
  endfunction

  task automatic t_div_code(input logic [7:0] c);
    int m, p, t, base;
    m = 1 << c[7:6]; p = int'(c[5:3]); t = int'(c[2:0]);
    base = ref_b(p) + (ref_s(t) - 1) * (1 << p);
    wr_reg(1'b1, c);
    addr = 1'b1; #1;
    chk("R2", "div readback", int'(rdata), int'(c));
    addr = 1'b0;
    chk("R9", "scl", int'(scl), 2 * m * (base + 2));
    chk("R9", "start hold", int'(sth), m * base);
    chk("R9", "stop hold", int'(sph), m * (base + 3));
    chk("R9", "sda hold", int'(sda), m * (ref_b(p) + (1 + t / 2 - 1) * (1 << p) + 3));
  endtask

  task automatic t_div;
    t_div_code(8'hBB);
    chk("R9", "0xBB scl", int'(scl), 8192);
    chk("R9", "0xBB sda", int'(sda), 1028);
    chk("R9", "0xBB start", int'(sth), 4088);
    chk("R9", "0xBB stop", int'(sph), 4100);
    t_div_code(8'hBF);
    chk("R9", "0xBF scl", int'(scl), 15360);
    chk("R9", "0xBF sda", int'(sda), 2052);
    chk("R9", "0xBF start", int'(sth), 7672);
    chk("R9", "0xBF stop", int'(sph), 7684);
    t_div_code(8'h00);
    t_div_code(8'h5A);
    t_div_code(8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_slave();
    t_start_stop();
    t_arb();
    t_irq();
    t_div();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WD_CYCLES) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule